// File: doc/BRIEF.md
# Basic-Block Instruction Hash Accumulator

This unit sits next to the fetch and decode stages of an in-order pipeline. It folds every fetched 32-bit instruction word of a basic block into a running XOR signature. The first fetch of a block latches the program counter as the block's start address. When decode flags a branch or jump, that instruction is folded in as well. One cycle later the unit presents the start address and the final signature, together with a single-cycle end strobe, to a downstream lookup-and-compare stage.

A block that grows past a configured instruction limit is treated as tampered code. The unit raises a one-cycle oversize exception and discards the partial signature, and the next fetch opens a fresh block. All updates happen alongside normal fetch, so no pipeline cycles are added. A synchronous flush input discards any partial block, for example on a pipeline redirect.

Top module: `bb_sig_accum`

## Requirements
- R1: After reset, and after any flush, the outputs are zero and both the end strobe and the exception are low. The next valid fetch opens a new block.
- R2: The PC of the first valid fetch of a block is the start address reported for that block. Later fetches of the same block do not change it.
- R3: The reported signature is the bitwise XOR of every instruction word of the block, including the terminating branch or jump. A bit that flips an even number of times cancels out.
- R4: `blkEnd` is high for exactly the one cycle after the cycle in which a valid fetch carries `isFlowCtl=1`. In that cycle `blkStart` and `blkHash` carry the block's values; in every other cycle they read zero.
- R5: The valid fetch that follows a block end opens a new block, with a fresh signature and a new start address.
- R6: Cycles with `fetchValid=0` leave the block state unchanged, so gaps inside a block do not alter its result.
- R7: If instruction number MAX_LEN+1 of a block is not a branch or jump, `oversizeExc` pulses for one cycle after it, no end strobe is given, and the block is discarded.
- R8: A block of exactly MAX_LEN instructions that ends in a branch or jump gives a normal end strobe and no exception.
- R9: If instruction number MAX_LEN+1 is itself a branch or jump, `blkEnd` and `oversizeExc` are asserted in the same cycle, and the start address and signature are reported.
- R10: A flush discards a partial block and produces no end strobe. A flush takes priority over a valid branch or jump fetched in the same cycle.
- R11: `isFlowCtl` has no effect while `fetchValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flushIn | input | 1 | Synchronous discard of all block state |
| fetchValid | input | 1 | A fetched instruction is present this cycle |
| fetchPc | input | ADDR_W | Address of the fetched instruction |
| fetchInstr | input | 32 | Fetched instruction word |
| isFlowCtl | input | 1 | Decode marks the instruction as a branch or jump |
| blkStart | output | ADDR_W | Start address of the finished block (valid with blkEnd) |
| blkHash | output | 32 | XOR signature of the finished block (valid with blkEnd) |
| blkEnd | output | 1 | One-cycle block-complete strobe |
| oversizeExc | output | 1 | One-cycle block-length violation |

## Verification
Block completion and the length violation can fall in the same cycle when the instruction that crosses the limit is itself a branch or jump. The stimulus table provokes this by feeding exactly MAX_LEN plain instructions and then a flow-control one. The result is judged correct only if both strobes rise together and the reported address and signature are those of the whole block. A second collision, a flush arriving together with a terminating branch, is provoked directly. It must suppress the end strobe, and the following block must start clean.

// File: rtl/bb_sig_pkg.sv
package bb_sig_pkg;
  localparam int INSTR_W = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;      // discard everything (flush)
    logic upd;      // a valid instruction is being folded in
    logic chain;    // continue the open block (else open a new one)
    logic publish;  // drive the block result onto the outputs next cycle
    logic drop;     // block closes: clear start and signature registers
  } bbStrobe_t;
endpackage

// File: rtl/bb_sig_ctrl.sv
module bb_sig_ctrl
  import bb_sig_pkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      flushIn,
  input  logic      fetchValid,
  input  logic      isFlowCtl,
  output bbStrobe_t strobe,
  output logic      blkEnd,
  output logic      oversizeExc
);
  localparam int CNT_W = $clog2(MAX_LEN + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LEN);

  logic             openQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic             take;
  logic             endHit;
  logic             overHit;
  logic             closing;

  always_comb begin
    take    = fetchValid && !flushIn;
    cntNext = (openQ ? cntQ : '0) + CNT_W'(1);
    endHit  = take && isFlowCtl;
    overHit = take && (cntNext > LIMIT);
    closing = endHit || overHit;

    strobe.clr     = flushIn;
    strobe.upd     = take;
    strobe.chain   = openQ;
    strobe.publish = endHit;
    strobe.drop    = closing;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openQ       <= 1'b0;
      cntQ        <= '0;
      blkEnd      <= 1'b0;
      oversizeExc <= 1'b0;
    end else if (flushIn) begin
      openQ       <= 1'b0;
      cntQ        <= '0;
      blkEnd      <= 1'b0;
      oversizeExc <= 1'b0;
    end else begin
      blkEnd      <= endHit;
      oversizeExc <= overHit;
      if (closing) begin
        openQ <= 1'b0;
        cntQ  <= '0;
      end else if (take) begin
        openQ <= 1'b1;
        cntQ  <= cntNext;
      end
    end
  end

  // R4
  end_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkEnd |-> $past(fetchValid && isFlowCtl && !flushIn));

  // R7
  over_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    oversizeExc |-> $past(fetchValid && !flushIn));

  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(flushIn) |-> (!blkEnd && !oversizeExc));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!fetchValid && !flushIn) |-> (!blkEnd && !oversizeExc && $stable(cntQ)));
endmodule

// File: rtl/bb_sig_dp.sv
module bb_sig_dp
  import bb_sig_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  bbStrobe_t          strobe,
  input  logic [ADDR_W-1:0]  fetchPc,
  input  logic [INSTR_W-1:0] fetchInstr,
  output logic [ADDR_W-1:0]  blkStart,
  output logic [INSTR_W-1:0] blkHash
);
  logic [ADDR_W-1:0]  startQ;
  logic [INSTR_W-1:0] hashQ;
  logic [ADDR_W-1:0]  startNext;
  logic [INSTR_W-1:0] hashNext;

  always_comb begin
    startNext = strobe.chain ? startQ : fetchPc;
    hashNext  = (strobe.chain ? hashQ : '0) ^ fetchInstr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ   <= '0;
      hashQ    <= '0;
      blkStart <= '0;
      blkHash  <= '0;
    end else if (strobe.clr) begin
      startQ   <= '0;
      hashQ    <= '0;
      blkStart <= '0;
      blkHash  <= '0;
    end else begin
      if (strobe.publish) begin
        blkStart <= startNext;
        blkHash  <= hashNext;
      end else begin
        blkStart <= '0;
        blkHash  <= '0;
      end
      if (strobe.drop) begin
        startQ <= '0;
        hashQ  <= '0;
      end else if (strobe.upd) begin
        startQ <= startNext;
        hashQ  <= hashNext;
      end
    end
  end

  // R5
  drop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.drop && !strobe.clr) |-> (startQ == '0 && hashQ == '0));

  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.upd && strobe.chain && !strobe.drop && !strobe.clr)
      |-> (startQ == $past(startQ)));

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clr) |-> (blkStart == '0 && blkHash == '0 && hashQ == '0));
endmodule

// File: rtl/bb_sig_accum.sv
module bb_sig_accum
  import bb_sig_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_LEN = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flushIn,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchPc,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic               isFlowCtl,
  output logic [ADDR_W-1:0]  blkStart,
  output logic [INSTR_W-1:0] blkHash,
  output logic               blkEnd,
  output logic               oversizeExc
);
  bbStrobe_t strobe;

  bb_sig_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flushIn     (flushIn),
    .fetchValid  (fetchValid),
    .isFlowCtl   (isFlowCtl),
    .strobe      (strobe),
    .blkEnd      (blkEnd),
    .oversizeExc (oversizeExc)
  );

  bb_sig_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fetchPc    (fetchPc),
    .fetchInstr (fetchInstr),
    .blkStart   (blkStart),
    .blkHash    (blkHash)
  );

  // R4
  out_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !blkEnd |-> (blkStart == '0 && blkHash == '0));
endmodule

// File: tb/bb_sig_accum_tb.sv
module bb_sig_accum_tb;
  localparam int AW  = 32;
  localparam int LIM = 5;

  typedef struct packed {
    logic        v;
    logic        f;
    logic [31:0] pc;
    logic [31:0] ins;
    logic        eEnd;
    logic        eOver;
    logic [31:0] eStart;
    logic [31:0] eHash;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 32'h100, 32'h11, 1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h104, 32'h22, 1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b0, 1'b1, 32'h108, 32'hFF, 1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b1, 32'h108, 32'h44, 1'b1, 1'b0, 32'h100, 32'h77},
    '{1'b1, 1'b1, 32'h200, 32'hABCD0000, 1'b1, 1'b0, 32'h200, 32'hABCD0000},
    '{1'b1, 1'b0, 32'h300, 32'h1,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h304, 32'h2,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b0, 1'b0, 32'h0,   32'h0,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h308, 32'h4,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h30C, 32'h8,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b1, 32'h310, 32'h10, 1'b1, 1'b0, 32'h300, 32'h1F},
    '{1'b1, 1'b0, 32'h400, 32'hF0, 1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h404, 32'hF0, 1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h408, 32'hF0, 1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h40C, 32'hF0, 1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h410, 32'hF0, 1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h414, 32'hF0, 1'b0, 1'b1, 32'h0,   32'h0},
    '{1'b1, 1'b1, 32'h500, 32'h5,  1'b1, 1'b0, 32'h500, 32'h5},
    '{1'b1, 1'b0, 32'h600, 32'h1,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h604, 32'h1,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h608, 32'h3,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h60C, 32'h0,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b0, 32'h610, 32'h0,  1'b0, 1'b0, 32'h0,   32'h0},
    '{1'b1, 1'b1, 32'h614, 32'h8,  1'b1, 1'b1, 32'h600, 32'hB}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          flushIn = 1'b0;
  logic          fetchValid = 1'b0;
  logic [AW-1:0] fetchPc = '0;
  logic [31:0]   fetchInstr = '0;
  logic          isFlowCtl = 1'b0;
  logic [AW-1:0] blkStart;
  logic [31:0]   blkHash;
  logic          blkEnd;
  logic          oversizeExc;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bb_sig_accum #(.ADDR_W(AW), .MAX_LEN(LIM)) u_dut (
    .clk(clk), .rstN(rstN), .flushIn(flushIn), .fetchValid(fetchValid),
    .fetchPc(fetchPc), .fetchInstr(fetchInstr), .isFlowCtl(isFlowCtl),
    .blkStart(blkStart), .blkHash(blkHash), .blkEnd(blkEnd),
    .oversizeExc(oversizeExc)
  );

  function automatic string vecReq(int i);
    if (i == 2) return "R11";
    if (i == 3) return "R2 R3 R4";
    if (i == 4) return "R5";
    if (i == 7) return "R6";
    if (i == 10) return "R8";
    if (i == 16) return "R7";
    if (i == 17) return "R7 R5";
    if (i == 23) return "R9";
    return "R4";
  endfunction

  task automatic check(string req, logic e, logic o, logic [31:0] s, logic [31:0] h);
    nRun++;
    if (blkEnd !== e || oversizeExc !== o || blkStart !== s || blkHash !== h) begin
      nFail++;
      $display("FAIL %s: got end=%0b exc=%0b start=%h hash=%h, expected end=%0b exc=%0b start=%h hash=%h",
               req, blkEnd, oversizeExc, blkStart, blkHash, e, o, s, h);
    end
  endtask

  task automatic drive(logic v, logic f, logic fl, logic [31:0] pc, logic [31:0] ins);
    @(negedge clk);
    fetchValid = v; isFlowCtl = f; flushIn = fl; fetchPc = pc; fetchInstr = ins;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1", 1'b0, 1'b0, 32'h0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].v, VECS[i].f, 1'b0, VECS[i].pc, VECS[i].ins);
      check(vecReq(i), VECS[i].eEnd, VECS[i].eOver, VECS[i].eStart, VECS[i].eHash);
    end

    // R10 flush mid-block discards partial block
    drive(1'b1, 1'b0, 1'b0, 32'h700, 32'h1);
    drive(1'b1, 1'b0, 1'b0, 32'h704, 32'h2);
    drive(1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
    check("R10", 1'b0, 1'b0, 32'h0, 32'h0);
    drive(1'b1, 1'b1, 1'b0, 32'h800, 32'h40);
    check("R1", 1'b1, 1'b0, 32'h800, 32'h40);

    // R10 flush together with a terminating branch
    drive(1'b1, 1'b0, 1'b0, 32'h900, 32'h3);
    drive(1'b1, 1'b1, 1'b1, 32'h904, 32'h4);
    check("R10", 1'b0, 1'b0, 32'h0, 32'h0);
    drive(1'b1, 1'b1, 1'b0, 32'hA00, 32'h9);
    check("R10", 1'b1, 1'b0, 32'hA00, 32'h9);

    // R1 reset in the middle of a block
    drive(1'b1, 1'b0, 1'b0, 32'hB00, 32'h7);
    @(negedge clk);
    fetchValid = 1'b0; isFlowCtl = 1'b0;
    rstN = 1'b0;
    #1;
    check("R1", 1'b0, 1'b0, 32'h0, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 32'hC00, 32'h2);
    check("R1", 1'b1, 1'b0, 32'hC00, 32'h2);

    drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    // R4 strobe lasts one cycle
    check("R4", 1'b0, 1'b0, 32'h0, 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule